// File: doc/BRIEF.md
# Striped Parity Memory Array Controller

This block places a cache line across a small array of memory lanes in the manner of a RAID-style stripe. There are four data lanes and one dedicated parity lane. A write takes one full cache line of eight 72-bit words. It sends the line out as two beats of four words, and each beat carries a parity word that is the bitwise XOR of that beat's four data words.

On a read, the five lanes deliver one word each in parallel. Each word comes with a good/bad flag from that lane's own error-check path; those decoders sit outside this block. When exactly one data lane is flagged bad, an output multiplexer replaces that lane's word with a word rebuilt from the three surviving data words and the parity word.

A per-lane disable input lets a lane be taken out of service while traffic keeps flowing. The read result leaves through a registered valid/ready stage, one beat at a time, in the order the beats arrived.

Top module: `stripe_parity_raid`

## Requirements
- R1: `wrReady` is high exactly when no write line is still being sent to the lanes. A line is captured on the cycle where `wrValid` and `wrReady` are both high.
- R2: Word w of a captured line is bits `[w*72 +: 72]` of `wrLine`. Beat b drives words b*4+k onto data lane k, in bits `[k*72 +: 72]` of `laneWrData`. `laneWrBeat` shows b, and beat 0 is sent before beat 1.
- R3: While `laneWrValid` is high, lane 4 of `laneWrData` (bits `[288 +: 72]`) equals the XOR of that beat's four data words.
- R4: A beat is accepted when `laneWrValid` and `laneWrReady` are both high. While `laneWrReady` is low, the beat's data and index stay unchanged. `laneWrValid` rises on the cycle after a line is captured.
- R5: In a read beat with no lane counted bad, the four data words pass to `rdOutData` unchanged. `rdOutCorrected`, `rdOutParityFault` and `rdOutUncorrectable` are then all low.
- R6: In a read beat where exactly one data lane k (0..3) is counted bad, output word k is the XOR of the other three data words and the parity word. `rdOutCorrected` is high and `rdOutFailLane` equals k. Whenever `rdOutCorrected` is low, `rdOutFailLane` is 0.
- R7: In a read beat where only the parity lane (bus index 4) is counted bad, the data words pass through unchanged and only `rdOutParityFault` is high.
- R8: In a read beat where two or more of the five lanes are counted bad, the data passes through unchanged and only `rdOutUncorrectable` is high. At most one of the three flags is ever high.
- R9: A lane counts as bad when its `rdInBad` bit or its `laneDisable` bit is set. Bit i of either input refers to bus lane i, with 4 being the parity lane.
- R10: `rdInReady` = !`rdOutValid` || `rdOutReady`. A beat accepted at a clock edge is presented on the outputs from that edge on, and is held while `rdOutReady` is low. `rdOutBeat` counts 0,1,0,1 over accepted beats, starting at 0 after reset.
- R11: After reset, `wrReady` is 1 and `laneWrValid` and `rdOutValid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Write line offered |
| wrReady | output | 1 | Write line can be taken |
| wrLine | input | 576 | Eight 72-bit words, word w at [w*72 +: 72] |
| laneWrValid | output | 1 | Write beat on the lanes is valid |
| laneWrReady | input | 1 | Lanes accept the write beat |
| laneWrBeat | output | 1 | Index of the current write beat |
| laneWrData | output | 360 | Four data lanes then the parity lane, 72 bits each |
| rdInValid | input | 1 | Read beat from the lanes is valid |
| rdInReady | output | 1 | Read beat can be taken |
| rdInData | input | 360 | Words from four data lanes then the parity lane |
| rdInBad | input | 5 | Per-lane bad flag from the error-check paths |
| laneDisable | input | 5 | Per-lane forced-bad control |
| rdOutValid | output | 1 | Read output beat valid |
| rdOutReady | input | 1 | Consumer takes the read output beat |
| rdOutBeat | output | 1 | Index of the read output beat |
| rdOutData | output | 288 | Four corrected data words |
| rdOutCorrected | output | 1 | One data lane was rebuilt in this beat |
| rdOutFailLane | output | 2 | Index of the rebuilt data lane |
| rdOutParityFault | output | 1 | Only the parity lane was bad |
| rdOutUncorrectable | output | 1 | Two or more lanes were bad |

## Verification
On every cycle, the checker confirms several things. The parity lane matches the XOR of the data lanes, and write beats advance in order and hold still under back-pressure. Read beats appear one edge after acceptance and hold while stalled, at most one status flag is raised, and beats with no bad lane or only a bad parity lane come through unaltered.

Whether a rebuilt word is actually correct, whether the failed-lane index is right, and whether disable bits are honoured can only be shown by the bench's scenarios. These scenarios run one failed lane at a time for each lane, pairs and triples of failures, disabled lanes, and random stalls on both handshakes, all against a behavioural model of the line and the flags.

// File: rtl/spr_pkg.sv
package spr_pkg;

  typedef struct packed {
    logic wrCapture;
    logic wrAdvance;
    logic rdCapture;
  } sprStrobe_t;

  typedef struct packed {
    logic corrected;
    logic parityFault;
    logic uncorrectable;
  } sprStatus_t;

endpackage

// File: rtl/spr_ctrl.sv
module spr_ctrl
  import spr_pkg::*;
#(
  parameter int BEATS = 2,
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  output logic              wrReady,
  output logic              laneWrValid,
  input  logic              laneWrReady,
  output logic [BEAT_W-1:0] wrBeat,
  input  logic              rdInValid,
  output logic              rdInReady,
  output logic              rdOutValid,
  input  logic              rdOutReady,
  output logic [BEAT_W-1:0] rdBeat,
  output sprStrobe_t        strobe
);

  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

  logic              wrBusyQ;
  logic [BEAT_W-1:0] wrBeatQ;
  logic              outValidQ;
  logic [BEAT_W-1:0] rdBeatQ;
  logic [BEAT_W-1:0] rdNextQ;

  // R1, R4: write side is busy from capture until the last beat is taken
  assign wrReady     = !wrBusyQ;
  assign laneWrValid = wrBusyQ;
  assign wrBeat      = wrBeatQ;

  // R10: single registered output stage
  assign rdInReady  = !outValidQ || rdOutReady;
  assign rdOutValid = outValidQ;
  assign rdBeat     = rdBeatQ;

  always_comb begin
    strobe           = '0;
    strobe.wrCapture = wrValid && !wrBusyQ;
    strobe.wrAdvance = wrBusyQ && laneWrReady;
    strobe.rdCapture = rdInValid && rdInReady;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrBusyQ <= 1'b0;
      wrBeatQ <= '0;
    end else if (strobe.wrCapture) begin
      wrBusyQ <= 1'b1;
      wrBeatQ <= '0;
    end else if (strobe.wrAdvance) begin
      if (wrBeatQ == LAST_BEAT) begin
        wrBusyQ <= 1'b0;
        wrBeatQ <= '0;
      end else begin
        wrBeatQ <= wrBeatQ + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValidQ <= 1'b0;
      rdBeatQ   <= '0;
      rdNextQ   <= '0;
    end else if (strobe.rdCapture) begin
      outValidQ <= 1'b1;
      rdBeatQ   <= rdNextQ;
      rdNextQ   <= (rdNextQ == LAST_BEAT) ? '0 : rdNextQ + 1'b1;
    end else if (rdOutReady) begin
      outValidQ <= 1'b0;
    end
  end

endmodule

// File: rtl/spr_rebuild.sv
module spr_rebuild
  import spr_pkg::*;
#(
  parameter int WORD_W = 72,
  parameter int LANES  = 4,
  localparam int BUS_W  = (LANES + 1) * WORD_W,
  localparam int DATA_W = LANES * WORD_W,
  localparam int LIDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [BUS_W-1:0]  laneData,
  input  logic [LANES:0]    laneBad,
  output logic [DATA_W-1:0] fixedData,
  output sprStatus_t        status,
  output logic [LIDX_W-1:0] failLane
);

  logic [WORD_W-1:0] syndrome;
  logic              singleData;
  int                nBad;

  // XOR of all five words; with one data word removed it rebuilds that word
  always_comb begin
    syndrome = '0;
    for (int k = 0; k <= LANES; k++) syndrome ^= laneData[k*WORD_W +: WORD_W];
  end

  always_comb begin
    nBad     = $countones(laneBad);
    failLane = '0;
    for (int k = LANES - 1; k >= 0; k--) if (laneBad[k]) failLane = LIDX_W'(k);
    singleData           = (nBad == 1) && !laneBad[LANES];
    status               = '0;
    status.corrected     = singleData;                        // R6
    status.parityFault   = (nBad == 1) && laneBad[LANES];     // R7
    status.uncorrectable = (nBad >= 2);                       // R8
    if (!singleData) failLane = '0;
  end

  for (genvar k = 0; k < LANES; k++) begin : g_mux
    logic [WORD_W-1:0] rawWord;
    assign rawWord = laneData[k*WORD_W +: WORD_W];
    assign fixedData[k*WORD_W +: WORD_W] =
      (singleData && laneBad[k]) ? (syndrome ^ rawWord) : rawWord;
  end

endmodule

// File: rtl/spr_datapath.sv
module spr_datapath
  import spr_pkg::*;
#(
  parameter int WORD_W = 72,
  parameter int LANES  = 4,
  parameter int BEATS  = 2,
  localparam int LINE_W = LANES * BEATS * WORD_W,
  localparam int BUS_W  = (LANES + 1) * WORD_W,
  localparam int DATA_W = LANES * WORD_W,
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1,
  localparam int LIDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  sprStrobe_t        strobe,
  input  logic [LINE_W-1:0] wrLine,
  input  logic [BEAT_W-1:0] wrBeat,
  output logic [BUS_W-1:0]  laneWrData,
  input  logic [BUS_W-1:0]  rdInData,
  input  logic [LANES:0]    rdInBad,
  input  logic [LANES:0]    laneDisable,
  output logic [DATA_W-1:0] rdOutData,
  output sprStatus_t        rdStatus,
  output logic [LIDX_W-1:0] rdFailLane
);

  logic [LINE_W-1:0] lineQ;
  logic [WORD_W-1:0] parityWord;

  always_ff @(posedge clk) begin
    if (strobe.wrCapture) lineQ <= wrLine;
  end

  // R2: striping of the held line over the data lanes
  for (genvar k = 0; k < LANES; k++) begin : g_stripe
    assign laneWrData[k*WORD_W +: WORD_W] =
      lineQ[(int'(wrBeat) * LANES + k) * WORD_W +: WORD_W];
  end

  // R3: parity word for the current beat
  always_comb begin
    parityWord = '0;
    for (int k = 0; k < LANES; k++) parityWord ^= laneWrData[k*WORD_W +: WORD_W];
  end
  assign laneWrData[LANES*WORD_W +: WORD_W] = parityWord;

  // R9: disable forces a lane to count as bad
  logic [LANES:0]    effBad;
  logic [DATA_W-1:0] fixedData;
  sprStatus_t        fixStatus;
  logic [LIDX_W-1:0] fixLane;

  assign effBad = rdInBad | laneDisable;

  spr_rebuild #(.WORD_W(WORD_W), .LANES(LANES)) u_rebuild (
    .laneData (rdInData),
    .laneBad  (effBad),
    .fixedData(fixedData),
    .status   (fixStatus),
    .failLane (fixLane)
  );

  always_ff @(posedge clk) begin
    if (strobe.rdCapture) rdOutData <= fixedData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdStatus   <= '0;
      rdFailLane <= '0;
    end else if (strobe.rdCapture) begin
      rdStatus   <= fixStatus;
      rdFailLane <= fixLane;
    end
  end

endmodule

// File: rtl/stripe_parity_raid.sv
module stripe_parity_raid
  import spr_pkg::*;
#(
  parameter int WORD_W = 72,
  parameter int LANES  = 4,
  parameter int BEATS  = 2,
  localparam int LINE_W = LANES * BEATS * WORD_W,
  localparam int BUS_W  = (LANES + 1) * WORD_W,
  localparam int DATA_W = LANES * WORD_W,
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1,
  localparam int LIDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  output logic              wrReady,
  input  logic [LINE_W-1:0] wrLine,
  output logic              laneWrValid,
  input  logic              laneWrReady,
  output logic [BEAT_W-1:0] laneWrBeat,
  output logic [BUS_W-1:0]  laneWrData,
  input  logic              rdInValid,
  output logic              rdInReady,
  input  logic [BUS_W-1:0]  rdInData,
  input  logic [LANES:0]    rdInBad,
  input  logic [LANES:0]    laneDisable,
  output logic              rdOutValid,
  input  logic              rdOutReady,
  output logic [BEAT_W-1:0] rdOutBeat,
  output logic [DATA_W-1:0] rdOutData,
  output logic              rdOutCorrected,
  output logic [LIDX_W-1:0] rdOutFailLane,
  output logic              rdOutParityFault,
  output logic              rdOutUncorrectable
);

  sprStrobe_t strobe;
  sprStatus_t rdStatus;

  spr_ctrl #(.BEATS(BEATS)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrValid    (wrValid),
    .wrReady    (wrReady),
    .laneWrValid(laneWrValid),
    .laneWrReady(laneWrReady),
    .wrBeat     (laneWrBeat),
    .rdInValid  (rdInValid),
    .rdInReady  (rdInReady),
    .rdOutValid (rdOutValid),
    .rdOutReady (rdOutReady),
    .rdBeat     (rdOutBeat),
    .strobe     (strobe)
  );

  spr_datapath #(.WORD_W(WORD_W), .LANES(LANES), .BEATS(BEATS)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .wrLine     (wrLine),
    .wrBeat     (laneWrBeat),
    .laneWrData (laneWrData),
    .rdInData   (rdInData),
    .rdInBad    (rdInBad),
    .laneDisable(laneDisable),
    .rdOutData  (rdOutData),
    .rdStatus   (rdStatus),
    .rdFailLane (rdOutFailLane)
  );

  assign rdOutCorrected     = rdStatus.corrected;
  assign rdOutParityFault   = rdStatus.parityFault;
  assign rdOutUncorrectable = rdStatus.uncorrectable;

endmodule

// File: rtl/stripe_parity_raid_chk.sv
module stripe_parity_raid_chk #(
  parameter int WORD_W = 72,
  parameter int LANES  = 4,
  parameter int BEATS  = 2,
  localparam int BUS_W  = (LANES + 1) * WORD_W,
  localparam int DATA_W = LANES * WORD_W,
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrReady,
  input logic              laneWrValid,
  input logic              laneWrReady,
  input logic [BEAT_W-1:0] laneWrBeat,
  input logic [BUS_W-1:0]  laneWrData,
  input logic              rdInValid,
  input logic              rdInReady,
  input logic [BUS_W-1:0]  rdInData,
  input logic [LANES:0]    rdInBad,
  input logic [LANES:0]    laneDisable,
  input logic              rdOutValid,
  input logic              rdOutReady,
  input logic [BEAT_W-1:0] rdOutBeat,
  input logic [DATA_W-1:0] rdOutData,
  input logic              rdOutCorrected,
  input logic              rdOutParityFault,
  input logic              rdOutUncorrectable
);

  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

  logic [WORD_W-1:0] lanesXor;
  logic [LANES:0]    badSeen;
  logic              rdTake;

  always_comb begin
    lanesXor = '0;
    for (int k = 0; k <= LANES; k++) lanesXor ^= laneWrData[k*WORD_W +: WORD_W];
  end
  assign badSeen = rdInBad | laneDisable;
  assign rdTake  = rdInValid && rdInReady;

  assert_parity_R3: assert property (@(posedge clk) disable iff (!rstN)
    laneWrValid |-> lanesXor == '0);

  assert_wr_busy_R4: assert property (@(posedge clk) disable iff (!rstN)
    laneWrValid |-> !wrReady);

  assert_wr_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    laneWrValid && !laneWrReady |=> laneWrValid && $stable(laneWrData) && $stable(laneWrBeat));

  assert_beat_order_R2: assert property (@(posedge clk) disable iff (!rstN)
    laneWrValid && laneWrReady && laneWrBeat != LAST_BEAT |=>
      laneWrValid && laneWrBeat == $past(laneWrBeat) + 1'b1);

  assert_rd_latency_R10: assert property (@(posedge clk) disable iff (!rstN)
    rdTake |=> rdOutValid);

  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    rdOutValid && !rdOutReady |=> rdOutValid && $stable(rdOutData) && $stable(rdOutBeat));

  assert_one_flag_R8: assert property (@(posedge clk) disable iff (!rstN)
    rdOutValid |-> $onehot0({rdOutCorrected, rdOutParityFault, rdOutUncorrectable}));

  assert_clean_pass_R5: assert property (@(posedge clk) disable iff (!rstN)
    rdTake && badSeen == '0 |=>
      rdOutData == $past(rdInData[DATA_W-1:0]) &&
      !rdOutCorrected && !rdOutParityFault && !rdOutUncorrectable);

  assert_parity_only_R7: assert property (@(posedge clk) disable iff (!rstN)
    rdTake && badSeen == {1'b1, {LANES{1'b0}}} |=>
      rdOutData == $past(rdInData[DATA_W-1:0]) && rdOutParityFault);

endmodule

bind stripe_parity_raid stripe_parity_raid_chk #(
  .WORD_W(WORD_W), .LANES(LANES), .BEATS(BEATS)
) u_chk (.*);

// File: tb/stripe_parity_raid_test.sv
module stripe_parity_raid_test;

  localparam int CLK_PERIOD = 10;
  localparam int WORD_W = 72;
  localparam int LANES  = 4;
  localparam int BEATS  = 2;
  localparam int LINE_W = LANES * BEATS * WORD_W;
  localparam int BUS_W  = (LANES + 1) * WORD_W;
  localparam int DATA_W = LANES * WORD_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrValid = 1'b0;
  logic wrReady;
  logic [LINE_W-1:0] wrLine = '0;
  logic laneWrValid;
  logic laneWrReady = 1'b1;
  logic [0:0] laneWrBeat;
  logic [BUS_W-1:0] laneWrData;
  logic rdInValid = 1'b0;
  logic rdInReady;
  logic [BUS_W-1:0] rdInData = '0;
  logic [LANES:0] rdInBad = '0;
  logic [LANES:0] laneDisable = '0;
  logic rdOutValid;
  logic rdOutReady = 1'b1;
  logic [0:0] rdOutBeat;
  logic [DATA_W-1:0] rdOutData;
  logic rdOutCorrected;
  logic [1:0] rdOutFailLane;
  logic rdOutParityFault;
  logic rdOutUncorrectable;

  stripe_parity_raid #(.WORD_W(WORD_W), .LANES(LANES), .BEATS(BEATS)) uut (.*);

  always #(CLK_PERIOD / 2) clk = ~clk;

  int    checks = 0;
  int    failures = 0;
  string curTag = "R5";
  bit    wrBp = 1'b0;
  bit    rdBp = 1'b0;
  bit    done = 1'b0;

  task automatic chk(input bit ok, input string tag, input string act, input string exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%s expected=%s", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic [BUS_W-1:0]  wrQ[$];
  int                wrBeatQ[$];
  bit                expValid = 1'b0;
  logic [DATA_W-1:0] expData;
  bit                expCorr, expPar, expUnc;
  int                expFail, expBeat;
  int                rdCnt = 0;

  task automatic modelRead();
    logic [LANES:0] bad;
    int nb, idx;
    logic [WORD_W-1:0] rebuilt;
    bad = rdInBad | laneDisable;
    nb = 0; idx = 0;
    for (int k = LANES; k >= 0; k--) if (bad[k]) begin nb++; idx = k; end
    expData = rdInData[DATA_W-1:0];
    expCorr = 0; expPar = 0; expUnc = 0; expFail = 0;
    if (nb >= 2) expUnc = 1;
    else if (nb == 1 && idx == LANES) expPar = 1;
    else if (nb == 1) begin
      rebuilt = '0;
      for (int k = 0; k <= LANES; k++)
        if (k != idx) rebuilt ^= rdInData[k*WORD_W +: WORD_W];
      expData[idx*WORD_W +: WORD_W] = rebuilt;
      expCorr = 1;
      expFail = idx;
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      wrQ.delete(); wrBeatQ.delete();
      expValid = 0; rdCnt = 0;
    end else begin
      if (laneWrValid && laneWrReady && wrQ.size() > 0) begin
        void'(wrQ.pop_front()); void'(wrBeatQ.pop_front());
      end
      if (wrValid && wrReady) begin
        for (int b = 0; b < BEATS; b++) begin
          logic [BUS_W-1:0] beat;
          logic [WORD_W-1:0] par;
          par = '0;
          for (int k = 0; k < LANES; k++) begin
            beat[k*WORD_W +: WORD_W] = wrLine[(b*LANES + k)*WORD_W +: WORD_W];
            par ^= wrLine[(b*LANES + k)*WORD_W +: WORD_W];
          end
          beat[LANES*WORD_W +: WORD_W] = par;
          wrQ.push_back(beat); wrBeatQ.push_back(b);
        end
      end
      if (rdInValid && (!expValid || rdOutReady)) begin
        modelRead();
        expValid = 1; expBeat = rdCnt; rdCnt = (rdCnt + 1) % BEATS;
      end else if (rdOutReady) expValid = 0;
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    #2;
    if (rstN && !done) begin
      chk(wrReady == (wrQ.size() == 0), "R1", $sformatf("%0b", wrReady), $sformatf("%0b", wrQ.size() == 0));
      chk(laneWrValid == (wrQ.size() > 0), "R4", $sformatf("%0b", laneWrValid), $sformatf("%0b", wrQ.size() > 0));
      if (laneWrValid && wrQ.size() > 0) begin
        chk(laneWrData[DATA_W-1:0] == wrQ[0][DATA_W-1:0], "R2",
            $sformatf("%h", laneWrData[DATA_W-1:0]), $sformatf("%h", wrQ[0][DATA_W-1:0]));
        chk(laneWrData[DATA_W +: WORD_W] == wrQ[0][DATA_W +: WORD_W], "R3",
            $sformatf("%h", laneWrData[DATA_W +: WORD_W]), $sformatf("%h", wrQ[0][DATA_W +: WORD_W]));
        chk(int'(laneWrBeat) == wrBeatQ[0], "R2", $sformatf("%0d", laneWrBeat), $sformatf("%0d", wrBeatQ[0]));
      end
      chk(rdInReady == (!expValid || rdOutReady), "R10", $sformatf("%0b", rdInReady), $sformatf("%0b", !expValid || rdOutReady));
      chk(rdOutValid == expValid, "R10", $sformatf("%0b", rdOutValid), $sformatf("%0b", expValid));
      if (rdOutValid && expValid) begin
        chk(rdOutData == expData, curTag, $sformatf("%h", rdOutData), $sformatf("%h", expData));
        chk({rdOutCorrected, rdOutParityFault, rdOutUncorrectable} == {expCorr, expPar, expUnc}, curTag,
            $sformatf("%b", {rdOutCorrected, rdOutParityFault, rdOutUncorrectable}),
            $sformatf("%b", {expCorr, expPar, expUnc}));
        chk(int'(rdOutFailLane) == expFail, "R6", $sformatf("%0d", rdOutFailLane), $sformatf("%0d", expFail));
        chk(int'(rdOutBeat) == expBeat, "R10", $sformatf("%0d", rdOutBeat), $sformatf("%0d", expBeat));
      end
    end
  end

  // ---------------- stimulus ----------------
  always @(negedge clk) begin
    laneWrReady = wrBp ? 1'($urandom % 2) : 1'b1;
    rdOutReady  = rdBp ? 1'($urandom % 2) : 1'b1;
  end

  function automatic logic [WORD_W-1:0] rword();
    logic [95:0] t;
    t = {$urandom, $urandom, $urandom};
    return t[WORD_W-1:0];
  endfunction

  task automatic sendWrite();
    logic [LINE_W-1:0] line;
    for (int w = 0; w < LANES * BEATS; w++) line[w*WORD_W +: WORD_W] = rword();
    @(negedge clk);
    wrValid = 1'b1; wrLine = line;
    #1;
    while (!wrReady) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    wrValid = 1'b0; wrLine = '0;
  endtask

  task automatic sendRead(input logic [LANES:0] bad);
    logic [BUS_W-1:0] d;
    for (int k = 0; k <= LANES; k++) d[k*WORD_W +: WORD_W] = rword();
    @(negedge clk);
    rdInValid = 1'b1; rdInData = d; rdInBad = bad;
    #1;
    while (!rdInReady) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    rdInValid = 1'b0; rdInBad = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #2;
    // R11 reset state
    chk(wrReady == 1'b1, "R11", $sformatf("%0b", wrReady), "1");
    chk(laneWrValid == 1'b0, "R11", $sformatf("%0b", laneWrValid), "0");
    chk(rdOutValid == 1'b0, "R11", $sformatf("%0b", rdOutValid), "0");

    // R1 R2 R3: free-flowing writes, then R4 with lane back-pressure
    repeat (3) sendWrite();
    idle(4);
    wrBp = 1'b1;
    repeat (6) sendWrite();
    idle(12);
    wrBp = 1'b0;
    idle(3);

    curTag = "R5";
    repeat (4) sendRead('0);
    idle(3);
    curTag = "R6";
    for (int k = 0; k < LANES; k++) begin
      sendRead(5'(1 << k));
      sendRead(5'(1 << k));
    end
    idle(3);
    curTag = "R7";
    repeat (2) sendRead(5'b10000);
    idle(3);
    curTag = "R8";
    sendRead(5'b00011); sendRead(5'b10100); sendRead(5'b01101); sendRead(5'b11111);
    idle(3);
    curTag = "R9";
    @(negedge clk); laneDisable = 5'b00010;
    sendRead('0); sendRead('0);
    sendRead(5'b01000);
    idle(3);
    @(negedge clk); laneDisable = 5'b10000;
    sendRead('0);
    idle(3);
    @(negedge clk); laneDisable = '0;
    idle(2);

    curTag = "R10";
    rdBp = 1'b1;
    for (int i = 0; i < 40; i++) begin
      logic [LANES:0] bad;
      case ($urandom % 4)
        0: bad = '0;
        1: bad = 5'(1 << ($urandom % 5));
        2: bad = 5'(($urandom % 31) + 1);
        default: bad = '0;
      endcase
      sendRead(bad);
    end
    rdBp = 1'b0;
    idle(6);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

endmodule